// File: doc/BRIEF.md
# Refresh Interrupt Timer

This block paces the memory-refresh service of a microprogrammed array controller. The host programs a 16-bit interval value; the block places that value in the upper bits of a 24-bit down counter with the low byte cleared. The programmable period is therefore a multiple of 256 clocks. Any value from 256 to 16,776,960 clocks can be set, which is 12.8 µs to about 0.839 s at 20 MHz. When the period runs out, the block raises a single interrupt request toward the sequencer. There are no priority levels, no nesting and no masking. The request stays up until the sequencer takes it at an instruction boundary.

When the sequencer acknowledges, it calls a fixed vector address that this block supplies. At the same moment the block drops an active-low refresh flag, and the counter reloads and starts over at once. A strobe from the end of the service routine raises the flag again. While the flag is low, the block holds back control-store write requests.

After reset the timer is idle. It starts only when the first sequence launch or direct instruction is seen, so the host can load the control store without being interrupted.

Top module: `refresh_irq_timer`

## Requirements
- R1: After reset `irq_req` is 0 and `refresh_active_n` is 1. No interrupt is raised, whatever interval is written, until the first `launch` pulse.
- R2: A `launch` pulse on an idle timer loads the counter with {interval, 8'h00}. `irq_req` rises exactly interval×256 clock edges after the loading edge.
- R3: The interval register resets to 0x1E85. A written value of 0 behaves as 1, giving 256 clocks.
- R4: Once raised, `irq_req` stays 1 until `irq_ack` is seen while it is 1. An `irq_ack` with no pending request has no effect on `irq_req` or on `refresh_active_n`.
- R5: An accepted acknowledge clears `irq_req` and drives `refresh_active_n` to 0 on the same edge. It also reloads the counter, so the next request rises interval×256 edges later.
- R6: A `svc_done` pulse returns `refresh_active_n` to 1 on the next edge. Without it the flag stays 0.
- R7: `cs_wr_grant` follows `cs_wr_req` while `refresh_active_n` is 1, and is 0 while it is 0.
- R8: A host write (`ival_wr`) while the timer runs restarts the count from the new value on the next edge. The next request then rises new_interval×256 edges after the write edge.
- R9: A `launch` pulse while the timer already runs does not disturb the count.
- R10: `vector_addr` always equals the parameter `VEC_ADDR` (default 12'hFF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ival_wr | input | 1 | Host write strobe for the interval value |
| ival_data | input | 16 | Interval value (units of 256 clocks) |
| launch | input | 1 | Sequence launch or direct instruction seen; arms the timer |
| irq_ack | input | 1 | Sequencer takes the interrupt at an instruction boundary |
| svc_done | input | 1 | End-of-service-routine strobe |
| cs_wr_req | input | 1 | Pending control-store write |
| irq_req | output | 1 | Refresh interrupt request |
| vector_addr | output | 12 | Fixed service routine address |
| refresh_active_n | output | 1 | Low while refresh service runs |
| cs_wr_grant | output | 1 | Control-store write allowed |

## Verification
The hardest situation to reach is an interval rewrite that must replace an expiry already scheduled, because the timing is only visible through when `irq_req` rises. The bench keeps a queue of predicted rise cycles. It retracts the stale prediction whenever it rewrites the interval in mid-count or with a zero value, and the monitor matches each rise against the queue. Small intervals of 1 and 2 keep each period at 256 or 512 clocks. A second reset with no interval write shows that the 0x1E85 default does not fire within the short windows.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;
  // Source of a counter (re)load in a given cycle.
  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_ARM   = 2'd1,
    LD_WRITE = 2'd2,
    LD_ACK   = 2'd3
  } load_src_e;
endpackage

// File: rtl/rit_interval_reg.sv
module rit_interval_reg #(
  parameter int PRESET_W = 16,
  parameter logic [PRESET_W-1:0] DEFAULT_IVAL = 16'h1E85
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PRESET_W-1:0] wr_data,
  output logic [PRESET_W-1:0] ival_q,
  output logic [PRESET_W-1:0] ival_next
);
  // Zero would give an empty interval; it is raised to the smallest step.
  function automatic logic [PRESET_W-1:0] clamp_ival(input logic [PRESET_W-1:0] v);
    if (v == '0) return {{(PRESET_W-1){1'b0}}, 1'b1};
    return v;
  endfunction

  logic [PRESET_W-1:0] wr_clamped;
  assign wr_clamped = clamp_ival(wr_data);
  assign ival_next  = wr_en ? wr_clamped : ival_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ival_q <= DEFAULT_IVAL;
    else if (wr_en) ival_q <= wr_clamped;
  end
endmodule

// File: rtl/rit_down_counter.sv
module rit_down_counter #(
  parameter int PRESET_W = 16,
  parameter int CNT_W    = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [PRESET_W-1:0] ival,
  input  logic                run,
  output logic                expire
);
  localparam int LOW_W = CNT_W - PRESET_W;

  // Interval value goes to the upper bits; the low byte always starts cleared.
  function automatic logic [CNT_W-1:0] start_value(input logic [PRESET_W-1:0] v);
    return {v, {LOW_W{1'b0}}};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign expire  = run && at_last && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= start_value(ival);
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rit_irq_ctrl.sv
module rit_irq_ctrl
  import refresh_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      launch,
  input  logic      ival_wr,
  input  logic      irq_ack,
  input  logic      svc_done,
  input  logic      expire,
  output logic      armed,
  output logic      irq_req,
  output logic      refresh_active_n,
  output logic      ack_evt,
  output logic      arm_evt,
  output load_src_e load_src
);
  assign ack_evt = irq_ack && irq_req;
  assign arm_evt = launch && !armed;

  // An accepted acknowledge and a host write both reload; either picks the
  // same next interval value, so the order here only names the source.
  always_comb begin
    if (ack_evt)      load_src = LD_ACK;
    else if (ival_wr) load_src = LD_WRITE;
    else if (arm_evt) load_src = LD_ARM;
    else              load_src = LD_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (arm_evt) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_req <= 1'b0;
    else if (ack_evt) irq_req <= 1'b0;
    else if (expire)  irq_req <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        refresh_active_n <= 1'b1;
    else if (ack_evt)  refresh_active_n <= 1'b0;
    else if (svc_done) refresh_active_n <= 1'b1;
  end
endmodule

// File: rtl/refresh_irq_timer.sv
module refresh_irq_timer
  import refresh_timer_pkg::*;
#(
  parameter int PRESET_W = 16,
  parameter int CNT_W    = 24,
  parameter int VEC_W    = 12,
  parameter logic [VEC_W-1:0]    VEC_ADDR     = 12'hFF0,
  parameter logic [PRESET_W-1:0] DEFAULT_IVAL = 16'h1E85
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ival_wr,
  input  logic [PRESET_W-1:0] ival_data,
  input  logic                launch,
  input  logic                irq_ack,
  input  logic                svc_done,
  input  logic                cs_wr_req,
  output logic                irq_req,
  output logic [VEC_W-1:0]    vector_addr,
  output logic                refresh_active_n,
  output logic                cs_wr_grant
);
  logic [PRESET_W-1:0] ival_q_w;
  logic [PRESET_W-1:0] ival_next_w;
  logic                armed_w;
  logic                expire_w;
  logic                ack_w;
  logic                arm_w;
  logic                load_w;
  logic                run_w;
  load_src_e           load_src_w;

  rit_interval_reg #(.PRESET_W(PRESET_W), .DEFAULT_IVAL(DEFAULT_IVAL)) ival_i (
    .clk(clk), .rst_n(rst_n), .wr_en(ival_wr), .wr_data(ival_data),
    .ival_q(ival_q_w), .ival_next(ival_next_w)
  );

  assign load_w = (load_src_w != LD_NONE);
  assign run_w  = armed_w && !irq_req;

  rit_down_counter #(.PRESET_W(PRESET_W), .CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(load_w), .ival(ival_next_w),
    .run(run_w), .expire(expire_w)
  );

  rit_irq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .ival_wr(ival_wr),
    .irq_ack(irq_ack), .svc_done(svc_done), .expire(expire_w),
    .armed(armed_w), .irq_req(irq_req), .refresh_active_n(refresh_active_n),
    .ack_evt(ack_w), .arm_evt(arm_w), .load_src(load_src_w)
  );

  assign vector_addr = VEC_ADDR;
  assign cs_wr_grant = cs_wr_req && refresh_active_n;
endmodule

// File: rtl/rit_checker.sv
module rit_checker (
  input logic clk,
  input logic rst_n,
  input logic armed,
  input logic expire,
  input logic arm_evt,
  input logic irq_ack,
  input logic svc_done,
  input logic irq_req,
  input logic refresh_active_n,
  input logic cs_wr_grant
);
  // R1
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !irq_req);
  // R1
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  // R2
  expire_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_req);
  // R9
  arm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !arm_evt);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);
  // R5
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (!irq_req && !refresh_active_n));
  // R5
  active_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refresh_active_n) |-> $past(irq_req && irq_ack));
  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_active_n && !svc_done && !irq_ack) |=> !refresh_active_n);
  // R7
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_active_n |-> !cs_wr_grant);
endmodule

bind refresh_irq_timer rit_checker chk_i (
  .clk(clk), .rst_n(rst_n), .armed(armed_w), .expire(expire_w),
  .arm_evt(arm_w), .irq_ack(irq_ack), .svc_done(svc_done),
  .irq_req(irq_req), .refresh_active_n(refresh_active_n),
  .cs_wr_grant(cs_wr_grant)
);

// File: tb/refresh_irq_timer_tb.sv
module refresh_irq_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ival_wr = 1'b0;
  logic [15:0] ival_data = '0;
  logic        launch = 1'b0;
  logic        irq_ack = 1'b0;
  logic        svc_done = 1'b0;
  logic        cs_wr_req = 1'b0;
  logic        irq_req;
  logic [11:0] vector_addr;
  logic        refresh_active_n;
  logic        cs_wr_grant;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct { int when; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_irq_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ival_wr(ival_wr), .ival_data(ival_data),
    .launch(launch), .irq_ack(irq_ack), .svc_done(svc_done),
    .cs_wr_req(cs_wr_req), .irq_req(irq_req), .vector_addr(vector_addr),
    .refresh_active_n(refresh_active_n), .cs_wr_grant(cs_wr_grant)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every rising request must match the oldest prediction.
  logic prev_irq = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) prev_irq <= 1'b0;
    else begin
      if (irq_req && !prev_irq) begin
        if (exp_q.size() == 0) check("R2 unexpected irq", cyc, -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.tag, cyc, e.when);
        end
      end
      prev_irq <= irq_req;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int when, input string tag);
    exp_t e;
    e.when = when; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_launch(output int edge_c);
    @(negedge clk) launch = 1'b1;
    @(posedge clk); #1 launch = 1'b0; edge_c = cyc;
  endtask

  task automatic do_ack(output int edge_c);
    @(negedge clk) irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0; edge_c = cyc;
  endtask

  task automatic do_done();
    @(negedge clk) svc_done = 1'b1;
    @(posedge clk); #1 svc_done = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] v, output int edge_c);
    @(negedge clk) begin ival_wr = 1'b1; ival_data = v; end
    @(posedge clk); #1 ival_wr = 1'b0; edge_c = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e0, e1, tgt;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R10 vector, R7 grant when idle
    check("R1 irq after reset", irq_req, 0);
    check("R1 active_n after reset", refresh_active_n, 1);
    check("R10 vector", vector_addr, 12'hFF0);
    cs_wr_req = 1'b1; #1;
    check("R7 grant while idle", cs_wr_grant, 1);
    cs_wr_req = 1'b0;

    // R1: short interval written but not launched -> nothing happens
    do_write(16'd1, e0);
    wait_cyc(600);
    check("R1 no irq before launch", irq_req, 0);
    // R4: stray acknowledge ignored
    do_ack(e0);
    @(negedge clk);
    check("R4 stray ack active_n", refresh_active_n, 1);
    check("R4 stray ack irq", irq_req, 0);

    // R2: launch, interval 1 -> 256 edges
    do_launch(e0);
    push(e0 + 256, "R2 first interval");
    wait_until(e0 + 100);
    do_launch(e1);  // R9: ignored while running
    wait_until(e0 + 256 + 20);
    check("R4 irq held", irq_req, 1);
    check("R9 irq count after relaunch", exp_q.size(), 0);

    // R5: acknowledge
    do_ack(e0);
    push(e0 + 256, "R5 reload after ack");
    @(negedge clk);
    check("R5 irq cleared", irq_req, 0);
    check("R5 active_n low", refresh_active_n, 0);
    cs_wr_req = 1'b1; #1;
    check("R7 grant blocked", cs_wr_grant, 0);
    wait_until(e0 + 50);
    check("R6 flag stays low", refresh_active_n, 0);
    do_done();
    @(negedge clk); #1;
    check("R6 flag released", refresh_active_n, 1);
    check("R7 grant restored", cs_wr_grant, 1);
    cs_wr_req = 1'b0;

    // R8: rewrite mid-count to 2 -> 512 edges from write
    wait_until(e0 + 100);
    do_write(16'd2, e1);
    void'(exp_q.pop_back());
    push(e1 + 512, "R8 restart on write");
    tgt = e1 + 512 + 5;
    wait_until(tgt);
    check("R8 irq after rewrite", irq_req, 1);

    do_ack(e0);
    push(e0 + 512, "R5 reload with new interval");
    wait_until(e0 + 10);
    // R3: zero behaves as one
    do_write(16'd0, e1);
    void'(exp_q.pop_back());
    push(e1 + 256, "R3 zero as one");
    wait_until(e1 + 256 + 5);
    check("R3 irq after zero write", irq_req, 1);
    do_ack(e0);
    push(e0 + 256, "R5 second reload");
    do_done();
    wait_until(e0 + 256 + 5);
    check("R5 irq after reload", irq_req, 1);
    check("R2 all predictions met", exp_q.size(), 0);

    // R3: reset default 0x1E85 does not fire within a short window
    @(negedge clk) rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    do_launch(e0);
    wait_cyc(1200);
    check("R3 default interval long", irq_req, 0);
    check("R1 flag after second reset", refresh_active_n, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule